// File: doc/BRIEF.md
# Soft interrupt and timer compare unit

This unit keeps a 17-bit soft-interrupt word, a 4-bit priority level, and three 64-bit timer compare registers: tick, system tick and hypervisor. It watches a free-running 63-bit counter. One write port covers five kinds of write:
- a direct write of the soft-interrupt word;
- a set-alias write that ORs bits into the word;
- a clear-alias write that removes bits from the word;
- a write of the level;
- writes to the three compare registers and to the hypervisor flag.

The outputs are a per-bit pending vector and a hypervisor interrupt flag. Bits 1 to 15 of the word pend only when their index is above the level. Bit 0 is the tick-match bit and bit 16 is the system-tick-match bit. Both pend only while the level is below 14.

Each compare register has a disable flag in bit 63 and a match value in bits 62:0. Each one drives a three-state comparator machine:
- `CMP_OFF`: the disable flag is set.
- `CMP_ARMED`: the comparator waits for the counter to equal the match value.
- `CMP_HIT`: the equality has already been reported.

The machine has these transitions:
- A write to the compare register (reload) goes to `CMP_OFF` or `CMP_ARMED`, depending on the new disable flag.
- `CMP_ARMED` goes to `CMP_HIT` on equality. It fires in that cycle unless blocked.
- `CMP_HIT` goes back to `CMP_ARMED` once the counter differs.
- Either active state goes to `CMP_OFF` if the flag is set.

A tick fire sets word bit 0, a system-tick fire sets bit 16, and a hypervisor fire sets the hypervisor flag. A halted strand blocks the hypervisor fire.

Top module: `sic_top`

## Requirements
- R1: After reset the word is zero, the level is zero, all three compare registers are disabled, and the pending vector and hypervisor flag are zero.
- R2: A write to address 0 replaces the word with write data bits 16:0.
- R3: A write to address 1 ORs write data bits 16:0 into the word.
- R4: A write to address 2 clears every word bit whose write data bit is 1.
- R5: For index i in 1..15, pending bit i is 1 exactly when word bit i is 1 and i is greater than the level (written at address 3, data bits 3:0).
- R6: Pending bits 0 and 16 follow word bits 0 and 16 only while the level is below 14, and are 0 otherwise.
- R7: The pending outputs reflect a word or level write in the first cycle after the write edge.
- R8: When the tick compare (address 4) has bit 63 clear and the counter equals its bits 62:0, word bit 0 is set at that clock edge. The system-tick compare (address 5) sets word bit 16 in the same way.
- R9: A compare register with bit 63 set never sets any bit.
- R10: A compare fires once per equality episode. A counter held at the match value does not fire again. A fire happens again after the counter moves away and returns, or after the compare register is rewritten.
- R11: The hypervisor compare (address 6) sets the hypervisor flag on a match. The flag stays at 1 until a write to address 7 loads it from data bit 0.
- R12: While `halted_i` is 1, a hypervisor match is dropped and does not set the flag.
- R13: A hardware match setting bit 0 or bit 16 in the same cycle as a direct or clear-alias write to the word is merged in, so the set bit survives.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_i | input | 63 | Free-running counter value |
| halted_i | input | 1 | Strand halted; blocks the hypervisor match |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Write target: 0 word, 1 set, 2 clear, 3 level, 4 tick compare, 5 system compare, 6 hypervisor compare, 7 hypervisor flag |
| wr_data_i | input | 64 | Write data |
| pend_o | output | 17 | Pending vector per word bit |
| hint_o | output | 1 | Hypervisor interrupt flag |

## Verification
The assertions assume two things about the inputs:
- The counter may hold or jump between cycles, so equality episodes can last several cycles.
- The write address always carries one of the eight encodings.

The one-shot and halt properties take the comparator fire signals as the reference for a match. The merge property assumes that a fire lands at the next edge regardless of a concurrent write to the word.

The stimulus stays inside these assumptions. It sweeps the counter upward through each match value and holds it at the match to probe refiring. It places writes exactly on match cycles, and it sweeps all sixteen levels against walking-one and full word patterns.

// File: rtl/sic_pkg.sv
package sic_pkg;
    localparam int SI_W   = 17;
    localparam int SI_TOP = 16;
    localparam int N_CMP  = 3;

    typedef enum logic [2:0] {
        A_SOFT  = 3'd0,
        A_SET   = 3'd1,
        A_CLR   = 3'd2,
        A_LEVEL = 3'd3,
        A_TCMP  = 3'd4,
        A_SCMP  = 3'd5,
        A_HCMP  = 3'd6,
        A_HFLAG = 3'd7
    } sic_addr_e;

    typedef enum logic [1:0] {
        CMP_OFF   = 2'd0,
        CMP_ARMED = 2'd1,
        CMP_HIT   = 2'd2
    } cmp_state_e;
endpackage

// File: rtl/sic_cmp.sv
module sic_cmp
    import sic_pkg::*;
#(
    parameter int CNT_W = 63
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic [CNT_W-1:0] match_i,
    input  logic             off_i,
    input  logic             reload_i,
    input  logic             reload_off_i,
    input  logic             block_i,
    output logic             fire_o
);
    cmp_state_e st_q, st_d;
    logic       eq;

    assign eq = (cnt_i == match_i);

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= CMP_OFF;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        if (reload_i) begin
            st_d = reload_off_i ? CMP_OFF : CMP_ARMED;
        end else begin
            unique case (st_q)
                CMP_OFF:   if (!off_i) st_d = CMP_ARMED;
                CMP_ARMED: if (off_i) st_d = CMP_OFF;
                           else if (eq) st_d = CMP_HIT;
                CMP_HIT:   if (off_i) st_d = CMP_OFF;
                           else if (!eq) st_d = CMP_ARMED;
                default:   st_d = CMP_OFF;
            endcase
        end
    end

    always_comb begin
        fire_o = (st_q == CMP_ARMED) && eq && !off_i && !block_i;
    end
endmodule

// File: rtl/sic_pend.sv
module sic_pend
    import sic_pkg::*;
#(
    parameter int PIL_W     = 4,
    parameter int LOW_LIMIT = 14
) (
    input  logic [SI_W-1:0]  si_i,
    input  logic [PIL_W-1:0] pil_i,
    output logic [SI_W-1:0]  pend_o
);
    localparam logic [PIL_W:0] LIMIT = (PIL_W+1)'(LOW_LIMIT);

    logic [PIL_W:0] lvl;
    logic           low_ok;

    assign lvl    = {1'b0, pil_i};
    assign low_ok = (lvl < LIMIT);

    assign pend_o[0]      = si_i[0] & low_ok;
    assign pend_o[SI_TOP] = si_i[SI_TOP] & low_ok;

    for (genvar i = 1; i < SI_TOP; i++) begin : g_mid
        localparam logic [PIL_W:0] IDX = (PIL_W+1)'(i);
        assign pend_o[i] = si_i[i] & (IDX > lvl);
    end
endmodule

// File: rtl/sic_top.sv
module sic_top
    import sic_pkg::*;
#(
    parameter int CNT_W     = 63,
    parameter int PIL_W     = 4,
    parameter int LOW_LIMIT = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic             halted_i,
    input  logic             wr_en_i,
    input  logic [2:0]       wr_addr_i,
    input  logic [CNT_W:0]   wr_data_i,
    output logic [SI_W-1:0]  pend_o,
    output logic             hint_o
);
    localparam int DW = CNT_W + 1;
    localparam logic [DW-1:0] CMP_RST = {1'b1, {CNT_W{1'b0}}};

    sic_addr_e          addr;
    logic [SI_W-1:0]    si_q, si_d;
    logic [PIL_W-1:0]   pil_q;
    logic [DW-1:0]      cmp_q [N_CMP];
    logic [N_CMP-1:0]   cmp_wr;
    logic [N_CMP-1:0]   cmp_off;
    logic [N_CMP-1:0]   fire;
    logic [N_CMP-1:0]   block;

    assign addr  = sic_addr_e'(wr_addr_i);
    assign block = {halted_i, 2'b00};

    for (genvar k = 0; k < N_CMP; k++) begin : g_cmp
        assign cmp_wr[k]  = wr_en_i && (wr_addr_i == 3'(int'(A_TCMP) + k));
        assign cmp_off[k] = cmp_q[k][DW-1];

        always_ff @(posedge clk) begin
            if (!rst_n)         cmp_q[k] <= CMP_RST;
            else if (cmp_wr[k]) cmp_q[k] <= wr_data_i;
        end

        sic_cmp #(.CNT_W(CNT_W)) u_cmp (
            .clk          (clk),
            .rst_n        (rst_n),
            .cnt_i        (cnt_i),
            .match_i      (cmp_q[k][CNT_W-1:0]),
            .off_i        (cmp_off[k]),
            .reload_i     (cmp_wr[k]),
            .reload_off_i (wr_data_i[DW-1]),
            .block_i      (block[k]),
            .fire_o       (fire[k])
        );
    end

    always_comb begin
        si_d = si_q;
        if (wr_en_i) begin
            unique case (addr)
                A_SOFT:  si_d = wr_data_i[SI_W-1:0];
                A_SET:   si_d = si_q | wr_data_i[SI_W-1:0];
                A_CLR:   si_d = si_q & ~wr_data_i[SI_W-1:0];
                default: si_d = si_q;
            endcase
        end
        si_d[0]      = si_d[0] | fire[0];
        si_d[SI_TOP] = si_d[SI_TOP] | fire[1];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            si_q   <= '0;
            pil_q  <= '0;
            hint_o <= 1'b0;
        end else begin
            si_q <= si_d;
            if (wr_en_i && addr == A_LEVEL) pil_q <= wr_data_i[PIL_W-1:0];
            if (fire[2])                           hint_o <= 1'b1;
            else if (wr_en_i && addr == A_HFLAG)   hint_o <= wr_data_i[0];
        end
    end

    sic_pend #(.PIL_W(PIL_W), .LOW_LIMIT(LOW_LIMIT)) u_pend (
        .si_i   (si_q),
        .pil_i  (pil_q),
        .pend_o (pend_o)
    );
endmodule

// File: rtl/sic_chk.sv
module sic_chk
    import sic_pkg::*;
#(
    parameter int CNT_W     = 63,
    parameter int PIL_W     = 4,
    parameter int LOW_LIMIT = 14
) (
    input logic             clk,
    input logic             rst_n,
    input logic             halted_i,
    input logic             wr_en_i,
    input logic [2:0]       wr_addr_i,
    input logic [CNT_W:0]   wr_data_i,
    input logic [SI_W-1:0]  pend_o,
    input logic             hint_o,
    input logic [SI_W-1:0]  si_q,
    input logic [PIL_W-1:0] pil_q,
    input logic [N_CMP-1:0] fire,
    input logic [N_CMP-1:0] cmp_off
);
    p_set_alias_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_addr_i == 3'd1) |=>
        ((si_q & $past(wr_data_i[SI_W-1:0])) == $past(wr_data_i[SI_W-1:0])));

    p_clear_alias_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_addr_i == 3'd2) |=>
        ((si_q[SI_TOP-1:1] & $past(wr_data_i[SI_TOP-1:1])) == '0));

    p_pend_subset_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((pend_o & ~si_q) == '0));

    p_top_level_masks_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (pil_q == '1) |-> (pend_o[SI_TOP-1:1] == '0));

    p_level_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (32'(pil_q) >= LOW_LIMIT) |-> (!pend_o[0] && !pend_o[SI_TOP]));

    p_tick_lands_r8: assert property (@(posedge clk) disable iff (!rst_n)
        fire[0] |=> si_q[0]);

    p_merge_r13: assert property (@(posedge clk) disable iff (!rst_n)
        fire[1] |=> si_q[SI_TOP]);

    p_disabled_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_off[0] || cmp_off[1] || cmp_off[2]) |->
        ((fire & cmp_off) == '0));

    p_one_shot_tick_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (fire[0] && !(wr_en_i && wr_addr_i == 3'd4)) |=> !fire[0]);

    p_one_shot_stick_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (fire[1] && !(wr_en_i && wr_addr_i == 3'd5)) |=> !fire[1]);

    p_one_shot_hyp_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (fire[2] && !(wr_en_i && wr_addr_i == 3'd6)) |=> !fire[2]);

    p_hint_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (hint_o && !(wr_en_i && wr_addr_i == 3'd7)) |=> hint_o);

    p_hint_on_fire_r11: assert property (@(posedge clk) disable iff (!rst_n)
        fire[2] |=> hint_o);

    p_halt_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
        halted_i |-> !fire[2]);
endmodule

bind sic_top sic_chk #(.CNT_W(CNT_W), .PIL_W(PIL_W), .LOW_LIMIT(LOW_LIMIT)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .halted_i  (halted_i),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .pend_o    (pend_o),
    .hint_o    (hint_o),
    .si_q      (si_q),
    .pil_q     (pil_q),
    .fire      (fire),
    .cmp_off   (cmp_off)
);

// File: tb/sic_top_test.sv
`timescale 1ns/1ps
module sic_top_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [62:0] cnt = '0;
    logic        halted = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [63:0] wr_data = '0;
    logic [16:0] pend;
    logic        hint;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    sic_top uut (
        .clk(clk), .rst_n(rst_n), .cnt_i(cnt), .halted_i(halted),
        .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
        .pend_o(pend), .hint_o(hint)
    );

    function automatic logic [16:0] exp_pend(logic [16:0] w, int lvl);
        logic [16:0] r = '0;
        for (int i = 1; i < 16; i++) r[i] = w[i] && (i > lvl);
        r[0]  = w[0]  && (lvl < 14);
        r[16] = w[16] && (lvl < 14);
        return r;
    endfunction

    task automatic check(string tag, logic [63:0] got, logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, got, exp);
        end
    endtask

    task automatic wr(logic [2:0] a, logic [63:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic sweep(logic [62:0] lo, logic [62:0] hi);
        for (logic [62:0] v = lo; v <= hi; v++) begin
            @(negedge clk);
            cnt = v;
        end
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset pend", 64'(pend), 64'h0);
        check("R1 reset hint", 64'(hint), 64'h0);

        // R5 R6 R7: sweep all levels against walking ones and full patterns
        for (int lvl = 0; lvl < 16; lvl++) begin
            wr(3'd3, 64'(lvl));
            for (int p = 0; p < 19; p++) begin
                logic [16:0] w;
                w = (p < 17) ? (17'h1 << p) : ((p == 17) ? 17'h1ffff : 17'h0aaaa);
                wr(3'd0, 64'(w));
                check($sformatf("R5/R6/R7 lvl=%0d w=%h", lvl, w), 64'(pend), 64'(exp_pend(w, lvl)));
            end
        end
        wr(3'd3, 64'd0);
        check("R7 level write takes effect next cycle", 64'(pend), 64'h0aaaa);

        wr(3'd0, 64'h1ffff);
        wr(3'd0, 64'h00005);
        check("R2 direct write replaces", 64'(pend), 64'h00005);
        wr(3'd1, 64'h00100);
        check("R3 set alias ORs", 64'(pend), 64'h00105);
        wr(3'd2, 64'h00004);
        check("R4 clear alias removes", 64'(pend), 64'h00101);
        wr(3'd0, 64'h0);

        // R8 tick compare exact cycle
        @(negedge clk); cnt = 63'd100;
        wr(3'd4, 64'd105);
        sweep(63'd101, 63'd104);
        check("R8 no early tick fire", 64'(pend), 64'h0);
        cnt = 63'd105;
        @(negedge clk);
        check("R8 tick fire sets bit 0", 64'(pend), 64'h00001);
        // R10 held counter does not refire
        wr(3'd2, 64'h1);
        repeat (3) @(negedge clk);
        check("R10 held counter no refire", 64'(pend), 64'h0);
        wr(3'd4, 64'd105);
        @(negedge clk);
        check("R10 rewrite rearms", 64'(pend), 64'h00001);
        wr(3'd2, 64'h1);
        cnt = 63'd106;
        @(negedge clk); cnt = 63'd107;
        @(negedge clk); cnt = 63'd105;
        @(negedge clk);
        check("R10 return to match refires", 64'(pend), 64'h00001);
        wr(3'd2, 64'h1);

        // R9 disabled compare
        wr(3'd4, (64'h1 << 63) | 64'd120);
        sweep(63'd110, 63'd130);
        check("R9 disabled tick compare quiet", 64'(pend), 64'h0);

        // R8 system compare
        wr(3'd5, 64'd140);
        sweep(63'd131, 63'd145);
        check("R8 stick fire sets bit 16", 64'(pend), 64'h10000);

        // R13 merge with direct and clear writes
        wr(3'd0, 64'h0);
        wr(3'd5, 64'd160);
        sweep(63'd150, 63'd159);
        cnt = 63'd160; wr_en = 1'b1; wr_addr = 3'd0; wr_data = 64'h2;
        @(negedge clk); wr_en = 1'b0;
        check("R13 direct write merged with match", 64'(pend), 64'h10002);
        wr(3'd5, 64'd170);
        @(negedge clk); cnt = 63'd169;
        @(negedge clk);
        cnt = 63'd170; wr_en = 1'b1; wr_addr = 3'd2; wr_data = 64'h1ffff;
        @(negedge clk); wr_en = 1'b0;
        check("R13 clear write merged with match", 64'(pend), 64'h10000);

        // R11 R12 hypervisor compare
        @(negedge clk); halted = 1'b1;
        wr(3'd6, 64'd200);
        sweep(63'd171, 63'd210);
        check("R12 halted blocks hypervisor match", 64'(hint), 64'h0);
        halted = 1'b0;
        wr(3'd6, 64'd220);
        sweep(63'd211, 63'd219);
        check("R11 no early hypervisor flag", 64'(hint), 64'h0);
        sweep(63'd220, 63'd230);
        check("R11 hypervisor match sets flag", 64'(hint), 64'h1);
        repeat (5) @(negedge clk);
        check("R11 flag holds", 64'(hint), 64'h1);
        wr(3'd7, 64'h0);
        check("R11 flag write clears", 64'(hint), 64'h0);
        check("R11 word untouched by hypervisor match", 64'(pend), 64'h10000);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule